// File: doc/BRIEF.md
# Dual-Source DMA Cycle Arbiter

This block is a bus master that takes the single-port system bus away from a CPU to serve two requestors. The first is a page copy: 256 bytes are read one at a time from a 256-byte page of memory and written to a fixed output port. The second is a sample fetch: one byte is read from an address that an audio channel supplies, and it is returned to that channel with a one-cycle strobe. Both requests arrive as single-cycle pulses and stay pending inside the block until they are served.

Work begins only when the CPU starts a read while a request is pending. In that cycle the block asserts the halt output and reads the CPU's own address. This is the halt cycle. From then on an external parity bit, which toggles every CPU cycle, sorts the cycles. An odd cycle is a put cycle and an even cycle is a get cycle. A page-copy read can only happen on a get cycle and its write on the next put cycle. A sample fetch can only be served on a get cycle that follows a put cycle seen while the fetch was pending. Cycles that have nothing to serve become dummy reads (get) or alignment reads (put) of the CPU address.

The controller has two states. IDLE takes the transition *start* (CPU read with a request pending) to RUN, and that cycle is the halt cycle. RUN takes the transition *finish* back to IDLE at the end of the cycle that leaves no request pending. The per-cycle actions are NONE, HALT_RD, SMP_RD, BLK_RD, DUMMY_RD, BLK_WR and ALIGN_RD.

Top module: `dma_pair_arbiter`

## Requirements
- R1: After reset `cpu_halt`, `bus_rd`, `bus_wr` and `smp_valid` are 0, and they stay 0 while no request is pending.
- R2: In IDLE, with a request pending and `cpu_rd` high, the block asserts `cpu_halt` and `bus_rd` in that same cycle with `bus_addr` = `cpu_addr`. `cpu_halt` then stays high until the end of the cycle after which no request is pending.
- R3: On a get cycle (`cycle_odd`=0) in RUN where the sample fetch is pending and ready, the block reads `smp_addr`. In the next cycle `smp_valid` is 1 for one cycle and `smp_data` equals the byte that was read.
- R4: A sample fetch becomes ready only through a put cycle (`cycle_odd`=1) in RUN that occurs while the fetch is pending. If the halt cycle falls on a get cycle, the fetch is served after 3 halt cycles in total. If it falls on a put cycle, the fetch is served after 4.
- R5: On a get cycle with a pending page copy and no ready sample fetch, the block reads address {page, count}. The page occupies the upper 8 bits and the count the lower 8 bits.
- R6: On a put cycle that directly follows a page-copy read, the block writes to address 0x2004 with `bus_wdata` equal to the byte just read, and the count advances by one.
- R7: A page copy makes exactly 256 writes from counts 0 to 255 and then ends. The run lasts 514 halt cycles when the halt cycle is on a get cycle and 513 when it is on a put cycle.
- R8: A get cycle with nothing to serve is a dummy read of `cpu_addr`. A put cycle with no write ready is an alignment read of `cpu_addr`.
- R9: When both are pending, a ready sample fetch wins the get cycle over the page-copy read. This adds exactly 2 cycles to the run.
- R10: A request pulse that arrives during RUN is served in the same run, without `cpu_halt` dropping.
- R11: A page request while a page copy is pending is ignored. It changes neither the page nor the count. A sample pulse while a fetch is pending adds no second delivery.
- R12: Pending requests do not halt the CPU until `cpu_rd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU is performing a read this cycle |
| cpu_addr | input | 16 | Address the CPU is presenting |
| cycle_odd | input | 1 | Global parity, 1 = put cycle, 0 = get cycle |
| blk_req | input | 1 | Page-copy request pulse |
| blk_page | input | 8 | Source page for the page copy |
| smp_req | input | 1 | Sample-fetch request pulse |
| smp_addr | input | 16 | Sample fetch address |
| bus_rdata | input | 8 | Read data from the bus |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data (last byte read) |
| cpu_halt | output | 1 | Holds the CPU off the bus |
| smp_valid | output | 1 | One-cycle strobe, sample byte delivered |
| smp_data | output | 8 | Delivered sample byte |

## Verification
Every internal flag of this block shows up at the bus within one or two cycles:

- A wrong ready or pending flag on either source turns a get cycle into the wrong kind of read, so `bus_addr` differs in that same cycle.
- A lost write-ready flag turns a write into an alignment read on the very next put cycle.
- A wrong copy count shows up at the next page read, as a wrong low address byte.
- An early or late end of a sequence shows up in the first cycle of `cpu_halt` that is missing or extra.

The bench therefore compares every bus output in every cycle against an independent cycle model. It also counts halt cycles, writes and deliveries over whole runs.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_HALT_RD,
        ACT_SMP_RD,
        ACT_BLK_RD,
        ACT_DUMMY_RD,
        ACT_BLK_WR,
        ACT_ALIGN_RD
    } cyc_act_e;

endpackage

// File: rtl/dma_req_track.sv
module dma_req_track
    import dma_arb_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_req,
    input  logic [PAGE_W-1:0] blk_page,
    input  logic              smp_req,
    input  logic              cycle_odd,
    input  cyc_act_e          act,
    input  logic              blk_last,
    output logic              blk_pend,
    output logic              smp_pend,
    output logic              smp_rdy,
    output logic              wr_rdy,
    output logic              blk_acc,
    output logic              all_clear_n,
    output logic [PAGE_W-1:0] page_q
);

    logic blk_pend_n;
    logic smp_pend_n;
    logic smp_rdy_n;
    logic wr_rdy_n;
    logic put_act;

    assign blk_acc = blk_req && !blk_pend;
    assign put_act = (act == ACT_BLK_WR) || (act == ACT_ALIGN_RD);

    always_comb begin
        blk_pend_n = blk_pend;
        if (blk_acc)
            blk_pend_n = 1'b1;
        else if (act == ACT_BLK_WR && blk_last)
            blk_pend_n = 1'b0;

        smp_pend_n = (smp_pend && (act != ACT_SMP_RD)) || smp_req;

        smp_rdy_n = smp_rdy;
        if (act == ACT_SMP_RD)
            smp_rdy_n = 1'b0;
        else if (put_act && smp_pend)
            smp_rdy_n = 1'b1;

        wr_rdy_n = wr_rdy;
        if (act == ACT_BLK_RD)
            wr_rdy_n = 1'b1;
        else if (act == ACT_BLK_WR)
            wr_rdy_n = 1'b0;
    end

    assign all_clear_n = !blk_pend_n && !smp_pend_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_pend <= 1'b0;
            smp_pend <= 1'b0;
            smp_rdy  <= 1'b0;
            wr_rdy   <= 1'b0;
            page_q   <= '0;
        end else begin
            blk_pend <= blk_pend_n;
            smp_pend <= smp_pend_n;
            smp_rdy  <= smp_rdy_n;
            wr_rdy   <= wr_rdy_n;
            if (blk_acc)
                page_q <= blk_page;
        end
    end

    AST_RDY_AFTER_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_rdy) |-> $past(cycle_odd)) else $error("fetch ready without put cycle"); // R4

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_pend && $past(blk_pend)) |-> $stable(page_q)) else $error("page changed mid copy"); // R11

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_rd,
    input  logic     cycle_odd,
    input  logic     blk_pend,
    input  logic     smp_pend,
    input  logic     smp_rdy,
    input  logic     wr_rdy,
    input  logic     all_clear_n,
    output cyc_act_e act,
    output logic     cpu_halt
);

    seq_state_e state_q;
    seq_state_e state_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    // transitions: start (IDLE->RUN), finish (RUN->IDLE)
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (act == ACT_HALT_RD) state_n = ST_RUN;
            ST_RUN:  if (all_clear_n)        state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // per-cycle action decode
    always_comb begin
        act = ACT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_rd && (blk_pend || smp_pend))
                    act = ACT_HALT_RD;
            end
            ST_RUN: begin
                if (cycle_odd) begin
                    if (blk_pend && wr_rdy)
                        act = ACT_BLK_WR;
                    else
                        act = ACT_ALIGN_RD;
                end else begin
                    if (smp_pend && smp_rdy)
                        act = ACT_SMP_RD;
                    else if (blk_pend)
                        act = ACT_BLK_RD;
                    else
                        act = ACT_DUMMY_RD;
                end
            end
            default: act = ACT_NONE;
        endcase
    end

    assign cpu_halt = (act != ACT_NONE);

    AST_HALT_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_halt) |-> (!blk_pend && !smp_pend)) else $error("halt released with work pending"); // R2

    AST_NO_HALT_WITHOUT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !$past(cpu_halt)) |-> cpu_rd) else $error("halt started without CPU read"); // R12

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
    import dma_arb_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h2004,
    localparam int               PAGE_W    = ADDR_W - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_act_e          act,
    input  logic              blk_acc,
    input  logic [PAGE_W-1:0] page_q,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              blk_last,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data
);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] obus_q;
    logic              smp_valid_q;

    assign blk_last = &cnt_q;

    always_comb begin
        bus_addr = cpu_addr;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        unique case (act)
            ACT_NONE:     bus_addr = cpu_addr;
            ACT_HALT_RD,
            ACT_DUMMY_RD,
            ACT_ALIGN_RD: begin
                bus_addr = cpu_addr;
                bus_rd   = 1'b1;
            end
            ACT_SMP_RD: begin
                bus_addr = smp_addr;
                bus_rd   = 1'b1;
            end
            ACT_BLK_RD: begin
                bus_addr = {page_q, cnt_q};
                bus_rd   = 1'b1;
            end
            ACT_BLK_WR: begin
                bus_addr = PORT_ADDR;
                bus_wr   = 1'b1;
            end
            default: bus_addr = cpu_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            obus_q      <= '0;
            smp_valid_q <= 1'b0;
        end else begin
            if (blk_acc)
                cnt_q <= '0;
            else if (act == ACT_BLK_WR)
                cnt_q <= cnt_q + 1'b1;
            if (bus_rd)
                obus_q <= bus_rdata;
            smp_valid_q <= (act == ACT_SMP_RD);
        end
    end

    assign bus_wdata = obus_q;
    assign smp_valid = smp_valid_q;
    assign smp_data  = obus_q;

    AST_CNT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_q) |-> ($past(bus_wr) || $past(blk_acc))) else $error("count moved without write"); // R6

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr})) else $error("read and write together"); // R8

    AST_DELIVER_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(bus_rd)) else $error("delivery without read"); // R3

endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
    import dma_arb_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h2004
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_rd,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      cycle_odd,
    input  logic                      blk_req,
    input  logic [ADDR_W-CNT_W-1:0]   blk_page,
    input  logic                      smp_req,
    input  logic [ADDR_W-1:0]         smp_addr,
    input  logic [DATA_W-1:0]         bus_rdata,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_rd,
    output logic                      bus_wr,
    output logic [DATA_W-1:0]         bus_wdata,
    output logic                      cpu_halt,
    output logic                      smp_valid,
    output logic [DATA_W-1:0]         smp_data
);

    localparam int PAGE_W = ADDR_W - CNT_W;

    cyc_act_e          act;
    logic              blk_pend;
    logic              smp_pend;
    logic              smp_rdy;
    logic              wr_rdy;
    logic              blk_acc;
    logic              all_clear_n;
    logic              blk_last;
    logic [PAGE_W-1:0] page_q;

    dma_req_track #(.PAGE_W(PAGE_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_req     (blk_req),
        .blk_page    (blk_page),
        .smp_req     (smp_req),
        .cycle_odd   (cycle_odd),
        .act         (act),
        .blk_last    (blk_last),
        .blk_pend    (blk_pend),
        .smp_pend    (smp_pend),
        .smp_rdy     (smp_rdy),
        .wr_rdy      (wr_rdy),
        .blk_acc     (blk_acc),
        .all_clear_n (all_clear_n),
        .page_q      (page_q)
    );

    dma_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd      (cpu_rd),
        .cycle_odd   (cycle_odd),
        .blk_pend    (blk_pend),
        .smp_pend    (smp_pend),
        .smp_rdy     (smp_rdy),
        .wr_rdy      (wr_rdy),
        .all_clear_n (all_clear_n),
        .act         (act),
        .cpu_halt    (cpu_halt)
    );

    dma_datapath #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .blk_acc   (blk_acc),
        .page_q    (page_q),
        .cpu_addr  (cpu_addr),
        .smp_addr  (smp_addr),
        .bus_rdata (bus_rdata),
        .blk_last  (blk_last),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );

    AST_WR_ON_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> cycle_odd) else $error("write on a get cycle"); // R6

    AST_SMP_ON_GET: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !$past(cycle_odd)) else $error("sample read on a put cycle"); // R3

endmodule

// File: tb/dma_pair_arbiter_bench.sv
module dma_pair_arbiter_bench;

    localparam int CLK_P = 10;

    typedef enum int {B_NONE, B_HALT, B_SMP, B_BRD, B_DUM, B_BWR, B_ALN} bact_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cycle_odd = 1'b0;
    logic        blk_req = 1'b0;
    logic [7:0]  blk_page = '0;
    logic        smp_req = 1'b0;
    logic [15:0] smp_addr = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic        cpu_halt;
    logic        smp_valid;
    logic [7:0]  smp_data;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic       m_active = 0, m_bp = 0, m_sp = 0, m_sr = 0, m_wr = 0, m_sv = 0;
    logic [7:0] m_cnt = 0, m_page = 0, m_ob = 0, m_sd = 0;
    logic       g_par = 0;

    // observation counters
    int  n_halt = 0, n_wr = 0, n_smp = 0, n_rise = 0;
    logic obs_halt = 0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    dma_pair_arbiter u_dma_pair_arbiter (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cycle_odd(cycle_odd), .blk_req(blk_req), .blk_page(blk_page),
        .smp_req(smp_req), .smp_addr(smp_addr), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cpu_halt(cpu_halt), .smp_valid(smp_valid),
        .smp_data(smp_data)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act_v, exp_v);
        end
    endtask

    function automatic bact_t model_act(input logic rd, input logic par);
        if (!m_active)
            return (rd && (m_bp || m_sp)) ? B_HALT : B_NONE;
        if (par)
            return (m_bp && m_wr) ? B_BWR : B_ALN;
        if (m_sp && m_sr)
            return B_SMP;
        return m_bp ? B_BRD : B_DUM;
    endfunction

    function automatic string tag_of(input bact_t a);
        case (a)
            B_NONE: return (m_bp || m_sp) ? "R12" : "R1";
            B_HALT: return "R2";
            B_SMP:  return m_bp ? "R9" : "R3";
            B_BRD:  return m_sp ? "R4" : "R5";
            B_DUM:  return m_sp ? "R4" : "R8";
            B_BWR:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic step(input logic rd, input logic br, input logic [7:0] pg,
                        input logic sr, input logic [15:0] ca, input logic [15:0] sa);
        bact_t       a;
        logic [15:0] ea;
        logic        erd, ewr;
        string       tg;
        cpu_rd = rd; blk_req = br; blk_page = pg; smp_req = sr;
        cpu_addr = ca; smp_addr = sa; cycle_odd = g_par;
        @(negedge clk);
        a   = model_act(rd, g_par);
        tg  = tag_of(a);
        erd = (a == B_HALT) || (a == B_SMP) || (a == B_BRD) || (a == B_DUM) || (a == B_ALN);
        ewr = (a == B_BWR);
        case (a)
            B_SMP:   ea = sa;
            B_BRD:   ea = {m_page, m_cnt};
            B_BWR:   ea = 16'h2004;
            default: ea = ca;
        endcase
        chk(tg, "cpu_halt", 32'(cpu_halt), 32'(a != B_NONE));
        chk(tg, "bus_rd", 32'(bus_rd), 32'(erd));
        chk(tg, "bus_wr", 32'(bus_wr), 32'(ewr));
        if (erd || ewr) chk(tg, "bus_addr", 32'(bus_addr), 32'(ea));
        if (ewr) chk("R6", "bus_wdata", 32'(bus_wdata), 32'(m_ob));
        chk("R3", "smp_valid", 32'(smp_valid), 32'(m_sv));
        if (m_sv) chk("R3", "smp_data", 32'(smp_data), 32'(m_sd));
        if (cpu_halt) n_halt++;
        if (cpu_halt && !obs_halt) n_rise++;
        if (bus_wr) n_wr++;
        if (smp_valid) n_smp++;
        obs_halt = cpu_halt;
        // model update
        m_sv = 1'b0;
        if (m_active && (a == B_BWR || a == B_ALN) && m_sp) m_sr = 1'b1;
        case (a)
            B_HALT, B_DUM, B_ALN: m_ob = mem_f(ca);
            B_SMP: begin m_ob = mem_f(sa); m_sp = 0; m_sr = 0; m_sv = 1; m_sd = m_ob; end
            B_BRD: begin m_ob = mem_f({m_page, m_cnt}); m_wr = 1; end
            B_BWR: begin
                m_wr = 0;
                if (m_cnt == 8'hFF) m_bp = 0;
                m_cnt = m_cnt + 1;
            end
            default: ;
        endcase
        if (br && !m_bp) begin m_bp = 1; m_page = pg; m_cnt = 0; end
        else if (br) begin end
        if (sr) m_sp = 1;
        if (a == B_HALT) m_active = 1;
        else if (m_active && !m_bp && !m_sp) m_active = 0;
        @(posedge clk);
        #1;
        g_par = ~g_par;
    endtask

    task automatic reset_counts();
        n_halt = 0; n_wr = 0; n_smp = 0; n_rise = 0;
    endtask

    task automatic align_par(input logic want);
        if (g_par != want) step(0, 0, 8'h00, 0, 16'h1234, 16'hC000);
    endtask

    task automatic drain(input int sr_at, input int sr_at2, input int br_at, input logic [7:0] br_pg);
        for (int i = 0; i < 2000; i++) begin
            step(1, i == br_at, br_pg, (i == sr_at) || (i == sr_at2),
                 16'($urandom), 16'($urandom));
            if (i > 0 && !obs_halt) break;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        chk("R1", "halt in reset", 32'(cpu_halt), 0);
        chk("R1", "rd in reset", 32'(bus_rd), 0);
        chk("R1", "wr in reset", 32'(bus_wr), 0);
        rst_n = 1'b1;
        step(0, 0, 8'h00, 0, 16'h0100, 16'hC000);
        step(1, 0, 8'h00, 0, 16'h0102, 16'hC000);

        // R12: pending sample, no CPU read -> no halt
        reset_counts();
        align_par(1'b1);
        step(0, 0, 8'h00, 1, 16'h0200, 16'hC123);
        for (int i = 0; i < 5; i++) step(0, 0, 8'h00, 0, 16'h0200, 16'hC123);
        chk("R12", "halt cycles while cpu_rd low", 32'(n_halt), 0);
        // parity after 6 steps starting at 1 is 1 -> halt on put cycle
        reset_counts();
        drain(-1, -1, -1, 8'h00);
        chk("R4", "halt cycles, halt on put", 32'(n_halt), 4);
        chk("R3", "deliveries", 32'(n_smp), 1);

        // R4: halt on get cycle -> 3 cycles
        align_par(1'b1);
        step(0, 0, 8'h00, 1, 16'h0300, 16'hD00D);
        reset_counts();
        drain(-1, -1, -1, 8'h00);
        chk("R4", "halt cycles, halt on get", 32'(n_halt), 3);

        // R7: page copy, halt on get
        align_par(1'b1);
        step(0, 1, 8'h37, 0, 16'h0400, 16'h0000);
        reset_counts();
        drain(-1, -1, -1, 8'h00);
        chk("R7", "writes", 32'(n_wr), 256);
        chk("R7", "halt cycles, get start", 32'(n_halt), 514);
        chk("R7", "copy ended", 32'(m_bp), 0);

        // R7: page copy, halt on put
        align_par(1'b0);
        step(0, 1, 8'h81, 0, 16'h0500, 16'h0000);
        reset_counts();
        drain(-1, -1, -1, 8'h00);
        chk("R7", "writes", 32'(n_wr), 256);
        chk("R7", "halt cycles, put start", 32'(n_halt), 513);

        // R9/R10/R11: sample and extra page request during a copy
        align_par(1'b0);
        step(0, 1, 8'h42, 0, 16'h0600, 16'h0000);
        reset_counts();
        drain(100, 101, 200, 8'hC4);
        chk("R9", "halt cycles with sample inserted", 32'(n_halt), 515);
        chk("R10", "single continuous halt", 32'(n_rise), 1);
        chk("R11", "one delivery for two pulses", 32'(n_smp), 1);
        chk("R11", "writes unchanged by second page request", 32'(n_wr), 256);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 3) == 0, ($urandom % 400) == 0, 8'($urandom),
                 ($urandom % 50) == 0, 16'($urandom), 16'($urandom));
        end
        // drain remaining work
        drain(-1, -1, -1, 8'h00);
        for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 0, 16'h0700, 16'h0000);
        chk("R1", "idle after drain", 32'(cpu_halt), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule